// File: doc/BRIEF.md
# Indexed interrupt configuration register stack

This block holds the per-interrupt configuration of one function and makes it reachable through a narrow configuration bus. The bus sees three 32-bit words: a read-only capability header, an index register and a dataport. Software writes the index register to choose one 32-bit entry of an internal stack. It then reads or writes that entry through the dataport. The stack holds a count of the implemented interrupts and, for each interrupt, a 64-bit definition word that is reached as a low half and a high half.

The interrupt sender sees every definition word in full on a flat output bus. It reports each request that expects an end-of-interrupt reply on a per-interrupt set strobe, and each returned end-of-interrupt on a clear strobe. Software can also clear the pending flag by writing a one to it. The number of interrupts (1 to 8) and the next-capability pointer are elaboration-time parameters.

Top module: `intcfg_stack`

## Requirements
- R1: A read of bus word 0 returns the header {type 80h in [31:24], 00h in [23:16], NEXT_PTR in [15:8], ID 08h in [7:0]}. Bus word 3 always reads zero.
- R2: A read raises cfg_rvalid and presents cfg_rdata in the cycle after cfg_rd_en. Bus word 1 is the index register: bits [7:0] are read/write and bits [31:8] read zero.
- R3: With index 01h the dataport reads NUM_INTR-1 (the highest interrupt number) and ignores writes.
- R4: With index 10h+2n the dataport reaches bits [31:0] of interrupt n's definition word. With index 11h+2n it reaches bits [63:32].
- R5: After reset each definition word is 0000_0000_F800_0001h: address byte [31:24] is F8h, mask bit 0 is 1, and all other bits are 0.
- R6: Bits [31:0] are all read/write. In the high half, bit 62 (pass-posted) and bits [55:32] are read/write, and bits [61:56] always read zero.
- R7: eoi_set_i[n] sets bit 63 (waiting-for-EOI) of interrupt n only while bit 5 (request EOI) is 1. Otherwise it has no effect.
- R8: Bit 63 is cleared by eoi_clr_i[n] or by a dataport write to the high half with bit 31 of the write data set. Writing 0 there leaves bit 63 unchanged.
- R9: When an effective set and a clear (hardware or software) fall in the same cycle, bit 63 ends at 1.
- R10: A dataport access with an index that maps to no entry reads zero, and the write changes no stored state.
- R11: intr_def_o[n*64 +: 64] carries interrupt n's definition word and shows a write in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 2 | Word select: 0 header, 1 index, 2 dataport, 3 unused |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd_en |
| eoi_set_i | input | NUM_INTR | Per interrupt: request that expects an EOI was sent |
| eoi_clr_i | input | NUM_INTR | Per interrupt: EOI returned |
| intr_def_o | output | NUM_INTR*64 | All definition words, interrupt n at bits n*64 |

## Verification
The waiting-for-EOI bit has three sources that can meet in one cycle: the hardware set strobe, the hardware clear strobe and a software write-one-to-clear through the dataport. The bench first clears the bit. In one cycle it then pulses the set strobe together with the clear strobe, and in a later cycle together with a high-half dataport write that has bit 31 set. Each time it expects bit 63 on intr_def_o to read 1 in the next cycle. It also drives a set while request-EOI is 0 and a write of 0 to bit 63, and checks that neither changes the bit.

// File: rtl/intcfg_pkg.sv
package intcfg_pkg;

   localparam int unsigned CFG_DW   = 32;
   localparam int unsigned CFG_AW   = 2;
   localparam int unsigned IDX_W    = 8;
   localparam int unsigned DEF_W    = 64;
   localparam int unsigned MAX_INTR = 8;

   localparam logic [7:0] CAP_ID   = 8'h08;
   localparam logic [7:0] CAP_TYPE = 8'h80;
   localparam logic [7:0] LAST_IDX = 8'h01;
   localparam logic [7:0] DEF_BASE = 8'h10;

   typedef enum logic [CFG_AW-1:0] {
      WSEL_HDR  = 2'd0,
      WSEL_IDX  = 2'd1,
      WSEL_DATA = 2'd2,
      WSEL_NONE = 2'd3
   } wsel_e;

   typedef struct packed {
      logic        waiting;
      logic        pass_pw;
      logic [5:0]  rsvd;
      logic [23:0] info_hi;
      logic [7:0]  addr_hi;
      logic [17:0] info_mid;
      logic        req_eoi;
      logic [2:0]  msg_type;
      logic        polarity;
      logic        mask;
   } intr_def_t;

   localparam intr_def_t DEF_RESET = '{
      waiting:  1'b0,
      pass_pw:  1'b0,
      rsvd:     6'h00,
      info_hi:  24'h0,
      addr_hi:  8'hF8,
      info_mid: 18'h0,
      req_eoi:  1'b0,
      msg_type: 3'h0,
      polarity: 1'b0,
      mask:     1'b1
   };

endpackage

// File: rtl/intcfg_idx_dec.sv
module intcfg_idx_dec
   import intcfg_pkg::*;
#(
   parameter int unsigned NUM_INTR = 4
) (
   input  logic [IDX_W-1:0]    idx,
   output logic                sel_last,
   output logic [NUM_INTR-1:0] sel_lo,
   output logic [NUM_INTR-1:0] sel_hi
);

   assign sel_last = (idx == LAST_IDX);

   for (genvar n = 0; n < NUM_INTR; n++) begin : g_slot
      localparam logic [IDX_W-1:0] LO_IDX = DEF_BASE + IDX_W'(2 * n);
      localparam logic [IDX_W-1:0] HI_IDX = DEF_BASE + IDX_W'(2 * n + 1);
      assign sel_lo[n] = (idx == LO_IDX);
      assign sel_hi[n] = (idx == HI_IDX);
   end

endmodule

// File: rtl/intcfg_def_reg.sv
module intcfg_def_reg
   import intcfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [CFG_DW-1:0] wdata,
   input  logic              hw_set,
   input  logic              hw_clr,
   output intr_def_t         q
);

   logic set_eff;
   logic clr_eff;
   logic unused_wbits;

   assign set_eff      = hw_set & q.req_eoi;
   assign clr_eff      = hw_clr | (wr_hi & wdata[31]);
   assign unused_wbits = ^wdata[29:24];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= DEF_RESET;
      end else begin
         if (wr_lo) begin
            {q.addr_hi, q.info_mid, q.req_eoi, q.msg_type, q.polarity, q.mask} <= wdata;
         end
         if (wr_hi) begin
            q.pass_pw <= wdata[30];
            q.info_hi <= wdata[23:0];
         end
         if (set_eff) begin
            q.waiting <= 1'b1;
         end else if (clr_eff) begin
            q.waiting <= 1'b0;
         end
         q.rsvd <= '0;
      end
   end

endmodule

// File: rtl/intcfg_rd_mux.sv
module intcfg_rd_mux
   import intcfg_pkg::*;
#(
   parameter int unsigned NUM_INTR = 4,
   parameter logic [7:0]  NEXT_PTR = 8'h00
) (
   input  logic [CFG_AW-1:0]         wsel,
   input  logic [IDX_W-1:0]          idx,
   input  logic                      sel_last,
   input  logic [NUM_INTR-1:0]       sel_lo,
   input  logic [NUM_INTR-1:0]       sel_hi,
   input  logic [NUM_INTR*DEF_W-1:0] defs,
   output logic [CFG_DW-1:0]         word
);

   localparam logic [CFG_DW-1:0] HDR_WORD  = {CAP_TYPE, 8'h00, NEXT_PTR, CAP_ID};
   localparam logic [CFG_DW-1:0] LAST_WORD = CFG_DW'(NUM_INTR - 1);

   logic [CFG_DW-1:0] data_word;

   always_comb begin
      data_word = '0;
      if (sel_last) data_word = LAST_WORD;
      for (int n = 0; n < NUM_INTR; n++) begin
         if (sel_lo[n]) data_word = defs[n*DEF_W +: CFG_DW];
         if (sel_hi[n]) data_word = defs[n*DEF_W + CFG_DW +: CFG_DW];
      end
   end

   always_comb begin
      case (wsel_e'(wsel))
         WSEL_HDR:  word = HDR_WORD;
         WSEL_IDX:  word = {{(CFG_DW-IDX_W){1'b0}}, idx};
         WSEL_DATA: word = data_word;
         default:   word = '0;
      endcase
   end

endmodule

// File: rtl/intcfg_stack.sv
module intcfg_stack
   import intcfg_pkg::*;
#(
   parameter int unsigned NUM_INTR = 4,
   parameter logic [7:0]  NEXT_PTR = 8'h58
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_wr_en,
   input  logic                      cfg_rd_en,
   input  logic [1:0]                cfg_addr,
   input  logic [31:0]               cfg_wdata,
   output logic [31:0]               cfg_rdata,
   output logic                      cfg_rvalid,
   input  logic [NUM_INTR-1:0]       eoi_set_i,
   input  logic [NUM_INTR-1:0]       eoi_clr_i,
   output logic [NUM_INTR*64-1:0]    intr_def_o
);

   if (NUM_INTR < 1 || NUM_INTR > MAX_INTR) begin : g_bad_count
      $error("intcfg_stack: NUM_INTR must lie in 1..%0d", MAX_INTR);
   end
   if (DEF_BASE + 2 * NUM_INTR > (1 << IDX_W)) begin : g_bad_map
      $error("intcfg_stack: index map exceeds index width");
   end

   logic [IDX_W-1:0]    idx_q;
   logic                sel_last;
   logic [NUM_INTR-1:0] sel_lo;
   logic [NUM_INTR-1:0] sel_hi;
   logic                data_wr;
   logic [CFG_DW-1:0]   rd_word;

   assign data_wr = cfg_wr_en && (wsel_e'(cfg_addr) == WSEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (cfg_wr_en && wsel_e'(cfg_addr) == WSEL_IDX) begin
         idx_q <= cfg_wdata[IDX_W-1:0];
      end
   end

   intcfg_idx_dec #(.NUM_INTR(NUM_INTR)) u_dec (
      .idx      (idx_q),
      .sel_last (sel_last),
      .sel_lo   (sel_lo),
      .sel_hi   (sel_hi)
   );

   for (genvar n = 0; n < NUM_INTR; n++) begin : g_intr
      intr_def_t def_q;
      intcfg_def_reg u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_lo  (data_wr & sel_lo[n]),
         .wr_hi  (data_wr & sel_hi[n]),
         .wdata  (cfg_wdata),
         .hw_set (eoi_set_i[n]),
         .hw_clr (eoi_clr_i[n]),
         .q      (def_q)
      );
      assign intr_def_o[n*DEF_W +: DEF_W] = def_q;
   end

   intcfg_rd_mux #(.NUM_INTR(NUM_INTR), .NEXT_PTR(NEXT_PTR)) u_mux (
      .wsel     (cfg_addr),
      .idx      (idx_q),
      .sel_last (sel_last),
      .sel_lo   (sel_lo),
      .sel_hi   (sel_hi),
      .defs     (intr_def_o),
      .word     (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata  <= '0;
         cfg_rvalid <= 1'b0;
      end else begin
         cfg_rvalid <= cfg_rd_en;
         if (cfg_rd_en) cfg_rdata <= rd_word;
      end
   end

endmodule

// File: rtl/intcfg_chk.sv
module intcfg_chk #(
   parameter int unsigned NUM_INTR = 4,
   parameter logic [7:0]  NEXT_PTR = 8'h58
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_wr_en,
   input logic                   cfg_rd_en,
   input logic [1:0]             cfg_addr,
   input logic [31:0]            cfg_wdata,
   input logic [31:0]            cfg_rdata,
   input logic                   cfg_rvalid,
   input logic [7:0]             idx,
   input logic [NUM_INTR-1:0]    eoi_set_i,
   input logic [NUM_INTR-1:0]    eoi_clr_i,
   input logic [NUM_INTR*64-1:0] intr_def_o
);

   logic idx_unmapped;
   assign idx_unmapped = (idx != 8'h01) && ((idx < 8'h10) || (idx >= 8'(16 + 2 * NUM_INTR)));

   // R2
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_en |=> cfg_rvalid);

   // R1
   header_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_en && cfg_addr == 2'd0) |=> (cfg_rdata == {8'h80, 8'h00, NEXT_PTR, 8'h08}));

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_en && cfg_addr == 2'd2 && idx_unmapped) |=> (cfg_rdata == 32'h0));

   for (genvar n = 0; n < NUM_INTR; n++) begin : g_chk
      // R7
      waiting_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_set_i[n] && intr_def_o[n*64+5]) |=> intr_def_o[n*64+63]);
      // R7
      waiting_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(intr_def_o[n*64+63]) |-> $past(eoi_set_i[n] && intr_def_o[n*64+5]));
      // R8
      waiting_hwclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_clr_i[n] && !(eoi_set_i[n] && intr_def_o[n*64+5])) |=> !intr_def_o[n*64+63]);
      // R8
      waiting_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr_en && cfg_addr == 2'd2 && idx == 8'(17 + 2 * n) && cfg_wdata[31]
          && !(eoi_set_i[n] && intr_def_o[n*64+5])) |=> !intr_def_o[n*64+63]);
      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_set_i[n] && intr_def_o[n*64+5] && eoi_clr_i[n]) |=> intr_def_o[n*64+63]);
   end

endmodule

bind intcfg_stack intcfg_chk #(.NUM_INTR(NUM_INTR), .NEXT_PTR(NEXT_PTR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr_en  (cfg_wr_en),
   .cfg_rd_en  (cfg_rd_en),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .cfg_rvalid (cfg_rvalid),
   .idx        (idx_q),
   .eoi_set_i  (eoi_set_i),
   .eoi_clr_i  (eoi_clr_i),
   .intr_def_o (intr_def_o)
);

// File: tb/test_intcfg_stack.sv
module test_intcfg_stack;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NI         = 4;
   localparam logic [7:0]  NPTR       = 8'h58;
   localparam logic [63:0] RST_DEF    = 64'h0000_0000_F800_0001;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr_en = 1'b0;
   logic            cfg_rd_en = 1'b0;
   logic [1:0]      cfg_addr = 2'd0;
   logic [31:0]     cfg_wdata = 32'h0;
   logic [31:0]     cfg_rdata;
   logic            cfg_rvalid;
   logic [NI-1:0]   eoi_set_i = '0;
   logic [NI-1:0]   eoi_clr_i = '0;
   logic [NI*64-1:0] intr_def_o;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [63:0] exp_def [NI];

   always #(CLK_PERIOD/2) clk = ~clk;

   intcfg_stack #(.NUM_INTR(NI), .NEXT_PTR(NPTR)) i_intcfg_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr_en  (cfg_wr_en),
      .cfg_rd_en  (cfg_rd_en),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .cfg_rvalid (cfg_rvalid),
      .eoi_set_i  (eoi_set_i),
      .eoi_clr_i  (eoi_clr_i),
      .intr_def_o (intr_def_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops one expected word for every returned read
   always @(negedge clk) begin
      if (rst_n && cfg_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected rvalid", 64'(cfg_rdata), 64'h0);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cfg_rdata == e, t, 64'(cfg_rdata), 64'(e));
         end
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      cfg_rd_en = 1'b1; cfg_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      cfg_rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [NI-1:0] s, input logic [NI-1:0] c);
      @(negedge clk);
      eoi_set_i = s; eoi_clr_i = c;
      @(negedge clk);
      eoi_set_i = '0; eoi_clr_i = '0;
   endtask

   task automatic check_defs(input string t);
      for (int n = 0; n < NI; n++) begin
         check(intr_def_o[n*64 +: 64] == exp_def[n], t, intr_def_o[n*64 +: 64], exp_def[n]);
      end
   endtask

   initial begin
      for (int n = 0; n < NI; n++) exp_def[n] = RST_DEF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state
      check(cfg_rvalid == 1'b0, "R5 rvalid at reset", 64'(cfg_rvalid), 64'h0);
      check_defs("R5 reset definition words");

      // R1 header and unused word
      bus_rd(2'd0, {8'h80, 8'h00, NPTR, 8'h08}, "R1 header word");
      bus_rd(2'd3, 32'h0, "R1 word 3 reads zero");

      // R2 index register width
      bus_wr(2'd1, 32'h1234_5601);
      bus_rd(2'd1, 32'h0000_0001, "R2 index readback");
      // R3 last-interrupt register, write ignored
      bus_rd(2'd2, 32'(NI - 1), "R3 last interrupt");
      bus_wr(2'd2, 32'hFFFF_FFFF);
      bus_rd(2'd2, 32'(NI - 1), "R3 last interrupt after write");
      check_defs("R3 write to count touches nothing");

      // R4 R5 index map at reset
      for (int n = 0; n < NI; n++) begin
         bus_wr(2'd1, 32'(8'h10 + 2 * n));
         bus_rd(2'd2, 32'hF800_0001, "R4 low half reset");
         bus_wr(2'd1, 32'(8'h11 + 2 * n));
         bus_rd(2'd2, 32'h0, "R4 high half reset");
      end

      // R6 R11 low half of interrupt 2
      bus_wr(2'd1, 32'h14);
      bus_wr(2'd2, 32'hA5A5_5A5A);
      exp_def[2][31:0] = 32'hA5A5_5A5A;
      check_defs("R11 low write visible");
      bus_rd(2'd2, 32'hA5A5_5A5A, "R6 low half readback");

      // R6 R8 high half of interrupt 1 with all ones
      bus_wr(2'd1, 32'h13);
      bus_wr(2'd2, 32'hFFFF_FFFF);
      exp_def[1][63:32] = 32'h40FF_FFFF;
      check_defs("R6 high half writable bits");
      bus_rd(2'd2, 32'h40FF_FFFF, "R6 reserved bits read zero");

      // R7 set ignored while request-EOI is 0
      pulse(4'b0001, 4'b0000);
      check_defs("R7 set without request EOI");
      bus_wr(2'd1, 32'h10);
      bus_wr(2'd2, 32'hF800_0020);
      exp_def[0][31:0] = 32'hF800_0020;
      pulse(4'b0001, 4'b0000);
      exp_def[0][63] = 1'b1;
      check_defs("R7 set with request EOI");

      // R8 write 0 has no effect, write 1 clears
      bus_wr(2'd1, 32'h11);
      bus_wr(2'd2, 32'h0000_0000);
      check_defs("R8 write zero keeps waiting");
      bus_wr(2'd2, 32'h8000_0000);
      exp_def[0][63] = 1'b0;
      check_defs("R8 software clear");
      pulse(4'b0001, 4'b0000);
      exp_def[0][63] = 1'b1;
      pulse(4'b0000, 4'b0001);
      exp_def[0][63] = 1'b0;
      check_defs("R8 hardware clear");

      // R9 set against hardware clear
      pulse(4'b0001, 4'b0001);
      exp_def[0][63] = 1'b1;
      check_defs("R9 set wins over hardware clear");
      pulse(4'b0000, 4'b0001);
      exp_def[0][63] = 1'b0;
      // R9 set against software write-one-to-clear
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h8000_0000; eoi_set_i = 4'b0001;
      @(negedge clk);
      cfg_wr_en = 1'b0; eoi_set_i = '0;
      exp_def[0][63] = 1'b1;
      check_defs("R9 set wins over software clear");

      // R10 unmapped indices
      bus_wr(2'd1, 32'(8'h10 + 2 * NI));
      bus_wr(2'd2, 32'hFFFF_FFFF);
      bus_rd(2'd2, 32'h0, "R10 index past last entry");
      check_defs("R10 write past last entry ignored");
      bus_wr(2'd1, 32'h02);
      bus_wr(2'd2, 32'hFFFF_FFFF);
      bus_rd(2'd2, 32'h0, "R10 index 02h");
      bus_wr(2'd1, 32'h0F);
      bus_rd(2'd2, 32'h0, "R10 index 0Fh");
      check_defs("R10 no state changed");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 all reads returned", 64'(exp_q.size()), 64'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule